// File: doc/BRIEF.md
# Serial Register Loader with Address Autoincrement

This block is a write-only slave on a three-wire serial link. It fills a local register file. The master pulls the active-low load strobe low and then clocks bits in on the rising edges of the serial clock. The first eight bits give a register address. Every following group of sixteen bits is a data word. Address and data both arrive least significant bit first.

Each complete word is written to the current address, and the address then steps up by one. One frame can therefore load a run of neighbouring registers, and it may begin anywhere in the 256-entry space. When the strobe returns high, the frame ends at once, and any word still incomplete at that moment is dropped.

Every complete word produces a one-cycle write pulse, with its address and data, in the serial clock domain. The same pulse updates a 256 x 16 register file, which a combinational read port exposes for checking. The serial master has no way to pause, so the write output is valid-only: there is no ready input and no back-pressure. A receiver that needs flow control must accept one word every sixteen serial clocks. Registers narrower than sixteen bits still take a full word, and the master fills the upper bits with zeros.

Top module: `serial_regload`

## Requirements
- R1: While rst_n is low, wr_en reads 0 and every register file entry reads 0x0000.
- R2: ser_din is sampled on rising ser_clk edges while load_n is low. The first 8 bits of a frame form the register address, and the first bit received is address bit 0.
- R3: The 16 bits after the address form a data word, first bit received is data bit 0. On the clock edge that samples the 24th bit, wr_en goes high with wr_addr equal to the frame address and wr_data equal to the word. The register file entry then holds that word from the following edge onward.
- R4: If load_n rises before all 16 bits of a word have arrived, that word produces no wr_en pulse, and the register it would have gone to keeps its old value.
- R5: After each complete word the target address rises by one. Word k of a frame (counting from 0) goes to frame address + k.
- R6: The target address wraps from 0xFF to 0x00 within a burst.
- R7: A rising edge of load_n clears the bit counter and the address phase at once, so the next frame always starts with a fresh 8-bit address. A partial address is discarded without any write.
- R8: While load_n is high, activity on ser_clk and ser_din causes no write and changes no register.
- R9: wr_en is high for exactly one ser_clk cycle per complete word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial clock; data sampled on rising edges |
| load_n | input | 1 | Active-low frame strobe; high ends the frame asynchronously |
| ser_din | input | 1 | Serial data, LSB first |
| rst_n | input | 1 | Active-low asynchronous reset of write stage and register file |
| wr_en | output | 1 | One-cycle write pulse per complete word (valid-only, no ready) |
| wr_addr | output | 8 | Register address of the current write |
| wr_data | output | 16 | Data word of the current write |
| rd_addr | input | 8 | Read port address into the register file |
| rd_data | output | 16 | Register file contents at rd_addr |

## Verification
Four properties are checked on every clock:
- the bit counter stays within the address and word limits;
- the address steps by one after each complete word, with the natural wrap at the top;
- each write pulse lasts a single cycle and carries the address that was current when its last bit arrived;
- the register file takes the pulsed data.

Only the directed scenarios can show the rest:
- LSB-first assembly of real values;
- dropping of a partial word or a partial address when the strobe rises;
- the fresh address phase after an abort;
- the absence of any effect while the strobe is high.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/srl_shifter.sv
// Bit counter and shift register. Cleared asynchronously by frame_clr.
module srl_shifter #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              frame_clr,
  input  logic              din,
  output logic              addr_load,
  output logic [ADDR_W-1:0] new_addr,
  output logic              word_done,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_addr_q;

  assign sh_nx     = {din, sh_q[DATA_W-1:1]};
  assign addr_load = in_addr_q && (cnt_q == CNT_W'(ADDR_W - 1));
  assign word_done = !in_addr_q && (cnt_q == CNT_W'(DATA_W - 1));
  assign new_addr  = sh_nx[DATA_W-1 -: ADDR_W];
  assign word      = sh_nx;

  always_ff @(posedge clk or posedge frame_clr) begin
    if (frame_clr) begin
      cnt_q     <= '0;
      in_addr_q <= 1'b1;
      sh_q      <= '0;
    end else begin
      sh_q <= sh_nx;
      if (addr_load) begin
        cnt_q     <= '0;
        in_addr_q <= 1'b0;
      end else if (word_done) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_ADDR_CNT_BOUND: assert property (@(posedge clk) disable iff (frame_clr)
    in_addr_q |-> (cnt_q < CNT_W'(ADDR_W))); // R2
  AST_WORD_CNT_BOUND: assert property (@(posedge clk) disable iff (frame_clr)
    !in_addr_q |-> (cnt_q < CNT_W'(DATA_W))); // R3
endmodule

// File: rtl/srl_addr_ctr.sv
// Current target address: loaded from the frame header, stepped per word.
module srl_addr_ctr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur_addr <= '0;
    else if (load)  cur_addr <= load_val;
    else if (step)  cur_addr <= cur_addr + 1'b1;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R5
endmodule

// File: rtl/srl_wr_stage.sv
// Registers the write pulse with its address and data.
module srl_wr_stage #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= word_done;
      if (word_done) begin
        wr_addr <= cur_addr;
        wr_data <= word;
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R9
  AST_PULSE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (wr_en && wr_addr == $past(cur_addr))); // R3
endmodule

// File: rtl/srl_regfile.sv
// Register file written by the write pulse, with a combinational read port.
module srl_regfile #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  AST_MEM_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data))); // R3
endmodule

// File: rtl/serial_regload.sv
module serial_regload
  import srl_pkg::*;
(
  input  logic              ser_clk,
  input  logic              load_n,
  input  logic              ser_din,
  input  logic              rst_n,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic  frame_clr;
  logic  addr_load;
  addr_t new_addr;
  logic  word_done;
  word_t word;
  addr_t cur_addr;

  // A high strobe or a reset ends the frame immediately (R7, R8).
  assign frame_clr = load_n | ~rst_n;

  srl_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shifter (
    .clk(ser_clk), .frame_clr(frame_clr), .din(ser_din),
    .addr_load(addr_load), .new_addr(new_addr),
    .word_done(word_done), .word(word)
  );

  srl_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(ser_clk), .rst_n(rst_n), .load(addr_load), .load_val(new_addr),
    .step(word_done), .cur_addr(cur_addr)
  );

  srl_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(ser_clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .cur_addr(cur_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  srl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(ser_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/test_serial_regload.sv
module test_serial_regload;
  logic        clk = 1'b0;
  logic        load_n = 1'b1;
  logic        din = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  rd_addr = 8'h00;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  int n_pulse = 0;
  int n_double = 0;
  logic        prev_en = 1'b0;
  logic [7:0]  log_a [8];
  logic [15:0] log_d [8];
  logic [15:0] tx_w [4];

  always #10 clk = ~clk;

  serial_regload i_serial_regload (
    .ser_clk(clk), .load_n(load_n), .ser_din(din), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (n_pulse < 8) begin
        log_a[n_pulse] = wr_addr;
        log_d[n_pulse] = wr_data;
      end
      n_pulse++;
      if (prev_en) n_double++;
    end
    prev_en = wr_en;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, int'(rd_data), int'(exp));
  endtask

  task automatic send_bit(input logic b);
    din = b;
    @(negedge clk);
  endtask

  // Address, nw full words from tx_w, then extra bits of tx_w[nw].
  task automatic send_frame(input logic [7:0] a, input int nw, input int extra);
    @(negedge clk);
    load_n = 1'b0;
    for (int i = 0; i < 8; i++) send_bit(a[i]);
    for (int k = 0; k < nw; k++)
      for (int i = 0; i < 16; i++) send_bit(tx_w[k][i]);
    for (int i = 0; i < extra; i++) send_bit(tx_w[nw][i]);
    load_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 wr_en in reset", int'(wr_en), 0);
    rd_chk("R1 reg 0x00", 8'h00, 16'h0000);
    rd_chk("R1 reg 0x80", 8'h80, 16'h0000);
    rd_chk("R1 reg 0xFF", 8'hFF, 16'h0000);
  endtask

  task automatic t_single;
    n_pulse = 0;
    tx_w[0] = 16'hA5C3;
    send_frame(8'h12, 1, 0);
    chk("R3 pulse count", n_pulse, 1);
    chk("R2 pulse address", int'(log_a[0]), 8'h12);
    chk("R3 pulse data", int'(log_d[0]), 16'hA5C3);
    rd_chk("R3 reg 0x12", 8'h12, 16'hA5C3);
    rd_chk("R2 reg 0x48 untouched", 8'h48, 16'h0000);
    chk("R9 single-cycle pulse", n_double, 0);
  endtask

  task automatic t_burst;
    n_pulse = 0;
    tx_w[0] = 16'h0001; tx_w[1] = 16'h8000; tx_w[2] = 16'h3C5A;
    send_frame(8'h40, 3, 0);
    chk("R5 pulse count", n_pulse, 3);
    chk("R5 third pulse address", int'(log_a[2]), 8'h42);
    rd_chk("R5 reg 0x40", 8'h40, 16'h0001);
    rd_chk("R5 reg 0x41", 8'h41, 16'h8000);
    rd_chk("R5 reg 0x42", 8'h42, 16'h3C5A);
    rd_chk("R5 reg 0x43 untouched", 8'h43, 16'h0000);
  endtask

  task automatic t_wrap;
    n_pulse = 0;
    tx_w[0] = 16'h1111; tx_w[1] = 16'h2222; tx_w[2] = 16'h3333;
    send_frame(8'hFE, 3, 0);
    chk("R6 wrapped address", int'(log_a[2]), 8'h00);
    rd_chk("R6 reg 0xFE", 8'hFE, 16'h1111);
    rd_chk("R6 reg 0xFF", 8'hFF, 16'h2222);
    rd_chk("R6 reg 0x00", 8'h00, 16'h3333);
  endtask

  task automatic t_partial;
    n_pulse = 0;
    tx_w[0] = 16'h7E7E; tx_w[1] = 16'hFFFF;
    send_frame(8'h41, 1, 10);
    chk("R4 only full word pulses", n_pulse, 1);
    rd_chk("R4 reg 0x41 written", 8'h41, 16'h7E7E);
    rd_chk("R4 reg 0x42 kept", 8'h42, 16'h3C5A);
  endtask

  task automatic t_addr_abort;
    n_pulse = 0;
    @(negedge clk);
    load_n = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    load_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no pulse on partial address", n_pulse, 0);
    tx_w[0] = 16'h0BEE;
    send_frame(8'h07, 1, 0);
    chk("R7 fresh address after abort", int'(log_a[0]), 8'h07);
    rd_chk("R7 reg 0x07", 8'h07, 16'h0BEE);
    rd_chk("R7 reg 0x1F untouched", 8'h1F, 16'h0000);
  endtask

  task automatic t_idle;
    n_pulse = 0;
    load_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      din = i[0] ^ i[2];
      @(negedge clk);
    end
    chk("R8 no pulse while strobe high", n_pulse, 0);
    rd_chk("R8 reg 0x07 unchanged", 8'h07, 16'h0BEE);
    rd_chk("R8 reg 0x12 unchanged", 8'h12, 16'hA5C3);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_burst();
    t_wrap();
    t_partial();
    t_addr_abort();
    t_idle();
    chk("R9 no back-to-back pulses", n_double, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule